// File: doc/BRIEF.md
# Transmit Request Pin Controller

This block drives one active-low output pin that serves one of two functions, picked by a function bit held inside the block. In ready mode the pin is a modem terminal-ready line: it is low whenever the software ready bit is set. In request mode the pin is a transmit service request. It goes low when the transmit buffer is empty, or when a synchronous frame has just had its CRC trailer sent. It stays low until a bus access serves it.

The bus strobes (data strobe, read strobe, write strobe) are asynchronous and active low. A two-stage synchronizer brings each one into the processor-clock domain, where its falling edge is detected. From the detection cycle a small counter runs for a fixed number of further clocks and then drops the request. If the buffer is still empty at that point, the request comes back one cycle later. A channel reset or a hardware reset returns the pin to ready mode.

Top module: `txreq_pin_ctrl`

## Requirements
- R1: While the function bit is 0 (ready mode), `pin_n` equals the inverse of `ready_bit` (`ready_bit`=1 gives `pin_n`=0), whatever the other inputs are.
- R2: In request mode with no request active, `tx_empty`=1 at a rising edge makes `pin_n` low after that edge.
- R3: In request mode, a one-cycle `crc_sent` pulse with `sync_mode`=1 makes `pin_n` low after that edge even when `tx_empty`=0. With `sync_mode`=0 the pulse has no effect on `pin_n`.
- R4: With a request active, a falling edge on any one of `ds_n`, `rd_n`, `wr_n` that lands between two clock edges makes `pin_n` high after the 5th rising edge that follows (2 synchronizer stages plus 3 release clocks). Before that edge the pin stays low.
- R5: A strobe falling edge has no effect while no request is active. It also has no effect while a release count is already running, so it neither restarts nor lengthens the count.
- R6: After a release, `pin_n` is high for exactly one cycle and then low again if `tx_empty` is still 1. It stays high if `tx_empty` is 0.
- R7: A `chan_reset` pulse or a low `rst_n` clears the function bit, so that ready mode (R1) applies after the edge.
- R8: In request mode `ready_bit` has no effect on `pin_n`. A write of the function bit (`fn_wr`=1 with `fn_wdata`) changes the pin behaviour from the next rising edge, not before it.
- R9: A `crc_sent` pulse that arrives while a request is already active merges into that request, so no extra request follows the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_reset | input | 1 | Synchronous channel reset, one-cycle pulse |
| fn_wr | input | 1 | Write enable for the function bit |
| fn_wdata | input | 1 | New function bit: 0 ready mode, 1 request mode |
| ready_bit | input | 1 | Software-controlled ready bit |
| ds_n | input | 1 | Bus data strobe, asynchronous, active low |
| rd_n | input | 1 | Bus read strobe, asynchronous, active low |
| wr_n | input | 1 | Bus write strobe, asynchronous, active low |
| tx_empty | input | 1 | Transmit buffer empty flag |
| crc_sent | input | 1 | One-cycle pulse: CRC trailer has been sent |
| sync_mode | input | 1 | Channel is running a synchronous protocol |
| pin_n | output | 1 | Pin level, active low |

## Verification
On every cycle the assertions check the following:
- the ready-mode mirror after a function write or a channel reset;
- that an idle request-mode block with an empty buffer asserts on the next edge;
- that an active request never drops without a strobe having started a release;
- that each drop comes at the end of a full count.

Only the bench scenarios can show the following:
- the exact five-edge latency from an asynchronous strobe edge, for each strobe;
- that strobes during a running count or with no request are ignored;
- the one-cycle gap before re-assertion;
- the merge of a CRC event into an active request;
- the sync-mode gating of CRC events.

// File: rtl/txreq_pkg.sv
package txreq_pkg;
   typedef enum logic {
      PIN_FN_READY   = 1'b0,
      PIN_FN_REQUEST = 1'b1
   } pin_fn_e;

   localparam int unsigned TXREQ_SYNC_STAGES_DEF  = 2;
   localparam int unsigned TXREQ_RELEASE_DEF      = 3;
   localparam int unsigned TXREQ_NUM_STROBES      = 3;
endpackage

// File: rtl/txreq_strobe_sync.sv
module txreq_strobe_sync #(
   parameter int unsigned NUM_STROBES = 3,
   parameter int unsigned STAGES      = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STROBES-1:0] strobe_n,
   output logic                   fall_any
);
   logic [NUM_STROBES-1:0] fall_vec;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("txreq_strobe_sync: STAGES must be at least 2");
      end
      if (NUM_STROBES < 1) begin : g_bad_count
         $error("txreq_strobe_sync: NUM_STROBES must be at least 1");
      end

      for (genvar g = 0; g < NUM_STROBES; g++) begin : g_lane
         logic [STAGES-1:0] sync_sh;
         logic              level_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_sh <= '1;
               level_q <= 1'b1;
            end else begin
               sync_sh <= {sync_sh[STAGES-2:0], strobe_n[g]};
               level_q <= sync_sh[STAGES-1];
            end
         end

         assign fall_vec[g] = level_q & ~sync_sh[STAGES-1];
      end
   endgenerate

   assign fall_any = |fall_vec;
endmodule

// File: rtl/txreq_release_timer.sv
module txreq_release_timer #(
   parameter int unsigned RELEASE_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(RELEASE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RELEASE_CYCLES - 1);
   localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (RELEASE_CYCLES < 2) begin : g_bad_release
         $error("txreq_release_timer: RELEASE_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (start && cnt_q == '0) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE_VAL;
      end
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == ONE_VAL);
endmodule

// File: rtl/txreq_pin_ctrl.sv
module txreq_pin_ctrl
   import txreq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = TXREQ_SYNC_STAGES_DEF,
   parameter int unsigned RELEASE_CYCLES = TXREQ_RELEASE_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_reset,
   input  logic fn_wr,
   input  logic fn_wdata,
   input  logic ready_bit,
   input  logic ds_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic tx_empty,
   input  logic crc_sent,
   input  logic sync_mode,
   output logic pin_n
);
   localparam int unsigned NSTB = TXREQ_NUM_STROBES;

   pin_fn_e         fn_q;
   logic            req_q;
   logic            fall_any;
   logic            busy;
   logic            done;
   logic            trig;
   logic            tmr_clr;
   logic            tmr_start;
   logic [NSTB-1:0] strobes_n;

   assign strobes_n = {wr_n, rd_n, ds_n};

   // Function select: cleared by hardware or channel reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_q <= PIN_FN_READY;
      end else if (chan_reset) begin
         fn_q <= PIN_FN_READY;
      end else if (fn_wr) begin
         fn_q <= pin_fn_e'(fn_wdata);
      end
   end

   txreq_strobe_sync #(
      .NUM_STROBES (NSTB),
      .STAGES      (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobes_n),
      .fall_any (fall_any)
   );

   assign tmr_clr   = chan_reset || (fn_q == PIN_FN_READY);
   assign tmr_start = req_q && !busy && fall_any;

   txreq_release_timer #(
      .RELEASE_CYCLES (RELEASE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .start (tmr_start),
      .busy  (busy),
      .done  (done)
   );

   // Request sources: empty buffer, or CRC trailer done in sync protocols
   assign trig = tx_empty || (crc_sent && sync_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (tmr_clr) begin
         req_q <= 1'b0;
      end else if (req_q) begin
         if (done) req_q <= 1'b0;
      end else if (trig) begin
         req_q <= 1'b1;
      end
   end

   always_comb begin
      if (fn_q == PIN_FN_REQUEST) pin_n = ~req_q;
      else                        pin_n = ~ready_bit;
   end
endmodule

// File: rtl/txreq_pin_ctrl_chk.sv
module txreq_pin_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic chan_reset,
   input logic fn_wr,
   input logic fn_wdata,
   input logic ready_bit,
   input logic tx_empty,
   input logic pin_n,
   input logic fn_bit,
   input logic req_q,
   input logic busy,
   input logic done,
   input logic fall_any
);
   // R1: write of ready mode gives the mirrored pin after the edge
   assert_ready_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_wr && !fn_wdata && !chan_reset) |=> (pin_n == !ready_bit));

   // R7: channel reset forces ready mode
   assert_chan_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset |=> (pin_n == !ready_bit));

   // R2: idle request mode with empty buffer asserts next edge
   assert_empty_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_bit && !req_q && tx_empty && !chan_reset && !(fn_wr && !fn_wdata))
      |=> !pin_n);

   // R4: an active request without release activity holds
   assert_hold_until_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_bit && req_q && !busy && !fall_any && !chan_reset) |=> req_q);

   // R5: a request only drops at the end of a full count
   assert_full_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(req_q) && $past(fn_bit) && !$past(chan_reset)) |-> $past(done));
endmodule

bind txreq_pin_ctrl txreq_pin_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_reset (chan_reset),
   .fn_wr      (fn_wr),
   .fn_wdata   (fn_wdata),
   .ready_bit  (ready_bit),
   .tx_empty   (tx_empty),
   .pin_n      (pin_n),
   .fn_bit     (fn_q),
   .req_q      (req_q),
   .busy       (busy),
   .done       (done),
   .fall_any   (fall_any)
);

// File: tb/test_txreq_pin_ctrl.sv
`timescale 1ns/1ps
module test_txreq_pin_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_reset = 1'b0;
   logic fn_wr = 1'b0;
   logic fn_wdata = 1'b0;
   logic ready_bit = 1'b0;
   logic ds_n = 1'b1;
   logic rd_n = 1'b1;
   logic wr_n = 1'b1;
   logic tx_empty = 1'b0;
   logic crc_sent = 1'b0;
   logic sync_mode = 1'b0;
   logic pin_n;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   localparam int LAT = 5; // 2 sync stages + 3 release clocks

   always #4 clk = ~clk;

   txreq_pin_ctrl i_txreq_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .fn_wr(fn_wr),
      .fn_wdata(fn_wdata), .ready_bit(ready_bit), .ds_n(ds_n), .rd_n(rd_n),
      .wr_n(wr_n), .tx_empty(tx_empty), .crc_sent(crc_sent),
      .sync_mode(sync_mode), .pin_n(pin_n)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      n_checks++;
      if (pin_n !== exp) begin
         n_fail++;
         $display("FAIL %s: pin_n actual=%b expected=%b at %0t", req, pin_n, exp, $time);
      end
   endtask

   task automatic set_strobe(input int s, input logic v);
      case (s)
         0: ds_n = v;
         1: rd_n = v;
         default: wr_n = v;
      endcase
   endtask

   task automatic write_fn(input logic v);
      fn_wr = 1'b1; fn_wdata = v;
      tick();
      fn_wr = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state: ready mode, ready_bit 0 -> pin high (R7)
      tick(); tick();
      check("R7 reset", 1'b1);
      rst_n = 1'b1;
      tick();
      check("R7 after reset", 1'b1);

      // R1 sweep in ready mode over ready, tx_empty, crc, sync
      for (int v = 0; v < 16; v++) begin
         ready_bit = v[0]; tx_empty = v[1]; crc_sent = v[2]; sync_mode = v[3];
         tick();
         check("R1 ready mirror", ~v[0]);
      end
      crc_sent = 1'b0; tx_empty = 1'b0; sync_mode = 1'b0;

      // R8: mode write takes effect only after the edge
      ready_bit = 1'b1; #1;
      check("R1 before write", 1'b0);
      fn_wr = 1'b1; fn_wdata = 1'b1; #1;
      check("R8 before edge", 1'b0);
      tick(); fn_wr = 1'b0; #1;
      check("R8 after edge", 1'b1);
      for (int v = 0; v < 4; v++) begin
         ready_bit = v[0];
         tick();
         check("R8 ready ignored", 1'b1);
      end

      // R4 / R6: each strobe, buffer still empty or not
      for (int s = 0; s < 3; s++) begin
         for (int emp = 0; emp < 2; emp++) begin
            tx_empty = 1'b1;
            tick();
            check("R2 request on empty", 1'b0);
            tx_empty = emp[0];
            tick();
            check("R2 request latched", 1'b0);
            set_strobe(s, 1'b0);
            for (int k = 1; k <= LAT + 3; k++) begin
               tick();
               if (k < LAT)       check("R4 held before release", 1'b0);
               else if (k == LAT) check("R4 release edge", 1'b1);
               else               check("R6 after release", emp[0] ? 1'b0 : 1'b1);
            end
            set_strobe(s, 1'b1);
            tx_empty = 1'b0;
            tick(); tick(); tick();
            if (emp == 0) check("R6 stays idle", 1'b1);
            else begin
               // release pending request left by empty buffer
               ds_n = 1'b0;
               for (int k = 1; k <= LAT; k++) tick();
               check("R4 cleanup release", 1'b1);
               ds_n = 1'b1;
               tick(); tick(); tick();
               check("R6 idle after cleanup", 1'b1);
            end
         end
      end

      // R5: strobe with no request is ignored
      wr_n = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         tick();
         check("R5 no request", 1'b1);
      end
      wr_n = 1'b1;
      tick(); tick();
      tx_empty = 1'b1;
      tick();
      check("R5 request after idle strobe", 1'b0);

      // R5: second strobe during running count is ignored
      ds_n = 1'b0;
      tick();
      rd_n = 1'b0;
      for (int k = 2; k <= LAT + 5; k++) begin
         tick();
         if (k == LAT) check("R5 release unchanged", 1'b1);
         else          check("R5 mid-window strobe ignored", 1'b0);
      end
      ds_n = 1'b1; rd_n = 1'b1;
      tx_empty = 1'b0;
      tick(); tick(); tick();
      ds_n = 1'b0;
      for (int k = 1; k <= LAT; k++) tick();
      check("R4 release to idle", 1'b1);
      ds_n = 1'b1;
      tick(); tick(); tick();

      // R3: CRC event gated by sync mode
      sync_mode = 1'b0; crc_sent = 1'b1;
      tick(); crc_sent = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R3 crc ignored async", 1'b1);
      end
      sync_mode = 1'b1; crc_sent = 1'b1;
      tick(); crc_sent = 1'b0;
      check("R3 crc request", 1'b0);
      tick();
      check("R3 crc request held", 1'b0);
      // R9: crc while active merges
      crc_sent = 1'b1;
      tick(); crc_sent = 1'b0;
      rd_n = 1'b0;
      for (int k = 1; k <= LAT + 3; k++) begin
         tick();
         if (k < LAT) check("R9 held", 1'b0);
         else         check("R9 merged, no extra request", 1'b1);
      end
      rd_n = 1'b1;
      tick(); tick(); tick();

      // R7: channel reset returns to ready mode
      ready_bit = 1'b1;
      tick();
      check("R8 ready ignored before reset", 1'b1);
      chan_reset = 1'b1;
      tick(); chan_reset = 1'b0; #1;
      check("R7 channel reset", 1'b0);
      ready_bit = 1'b0; #1;
      check("R7 ready mode mirror", 1'b1);

      // R8: switching back to ready with a live request
      write_fn(1'b1);
      tx_empty = 1'b1;
      tick();
      check("R2 request again", 1'b0);
      fn_wr = 1'b1; fn_wdata = 1'b0; #1;
      check("R8 before switch edge", 1'b0);
      tick(); fn_wr = 1'b0; #1;
      check("R8 switched to ready", 1'b1);

      // R7: hardware reset
      write_fn(1'b1);
      tick();
      check("R2 request before hw reset", 1'b0);
      rst_n = 1'b0; #1;
      check("R7 hardware reset", 1'b1);
      tick(); rst_n = 1'b1;
      tick();
      check("R7 ready after hw reset", 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule